// File: doc/BRIEF.md
# Accumulator CPU Opcode Decoder

This block turns one 8-bit opcode byte into a micro-operation descriptor for the execute stage of a small accumulator CPU. The descriptor gives an instruction class, a destination operand and a source operand (each a kind plus a 3-bit register index), a post-operation on the HL pointer, a logic-function selector, and the machine-cycle count and byte length of the instruction. The block covers a chosen subset of the opcode map: loads and stores through HL with pointer stepping, stores to a direct or high-page address, logic operations with memory at HL, register copies, immediate loads, call, return, interrupt disable and halt. Every other byte is flagged illegal. Operand fetch and execution happen elsewhere.

Two decode paths run side by side. One matches single opcodes exactly. The other matches the fixed-field register groups. A priority merge gives the exact table precedence over the field patterns. By default the descriptor is registered, so it appears one clock after the opcode is sampled. With `REG_OUT = 0` the descriptor follows the opcode combinationally.

Encodings used on the ports:
- Class: 0 illegal, 1 load, 2 store, 3 logic, 4 call, 5 return, 6 interrupt disable, 7 halt.
- Operand kind: 0 none, 1 register, 2 immediate byte, 3 memory at HL, 4 direct 16-bit address, 5 high-page address.
- Post-operation: 0 none, 1 increment HL, 2 decrement HL.
- Logic function: 0 none, 1 OR, 2 XOR, 3 AND.
- Register index: B=0, C=1, D=2, E=3, H=4, L=5, A=7. A register index reads 0 whenever its kind is not register.

Top module: `op_decoder`

## Requirements
- R1: With the default `REG_OUT = 1`, the descriptor for an opcode appears on the outputs one clock edge after that opcode is sampled. While `rst` is high at an edge, every output becomes 0 at that edge.
- R2: 0xEA gives class store (2), destination direct address (4), source register A (7), 4 cycles and 3 bytes. 0xE0 gives class store, destination high page (5), source register A, 3 cycles and 2 bytes.
- R3: 0x22 and 0x32 give class store, destination memory at HL (3), source register A, 2 cycles and 1 byte. Their post-operation is increment (1) for 0x22 and decrement (2) for 0x32.
- R4: 0x2A and 0x3A give class load (1), destination register A, source memory at HL, 2 cycles and 1 byte. Their post-operation is increment for 0x2A and decrement for 0x3A.
- R5: 0xB6, 0xAE and 0xA6 give class logic (3), destination register A, source memory at HL, 2 cycles and 1 byte. The logic function is OR (1), XOR (2) and AND (3) respectively, and the logic function is nonzero only for class logic.
- R6: 0xCD gives call (4) with 6 cycles and 3 bytes. 0xC9 gives return (5) with 4 cycles and 1 byte. 0xF3 gives interrupt disable (6) with 1 cycle and 1 byte. Both operands of these three are kind none.
- R7: A byte of the form 00_rrr_110 gives source immediate (2), 2 cycles and 2 bytes. If rrr is not 6, the class is load with destination register rrr. If rrr is 6, the class is store with destination memory at HL.
- R8: A byte of the form 01_ddd_sss, other than 0x76, gives 1 cycle and 1 byte. Bits 5:3 select the destination and bits 2:0 select the source. A field value of 6 gives kind memory at HL and never register index 6. The class is store when the destination is memory and load otherwise.
- R9: 0x76 gives class halt (7), kinds none, 1 cycle and 1 byte. The single-opcode table takes priority over the field patterns.
- R10: Every other byte raises `illegal_o` with class 0, both kinds none, post-operation none, 1 cycle and 1 byte. Exactly 172 of the 256 byte values are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opcode_i | input | 8 | Opcode byte to decode |
| cls_o | output | 3 | Instruction class |
| dst_kind_o | output | 3 | Destination operand kind |
| dst_reg_o | output | 3 | Destination register index |
| src_kind_o | output | 3 | Source operand kind |
| src_reg_o | output | 3 | Source register index |
| post_o | output | 2 | HL post-operation |
| logic_o | output | 2 | Logic function selector |
| cycles_o | output | 3 | Machine-cycle count |
| len_o | output | 2 | Instruction length in bytes |
| illegal_o | output | 1 | Opcode is outside the decoded subset |

## Verification
The assertions assume that `opcode_i` is a known byte at every sampled edge. They also assume that reset is applied for at least one edge before any descriptor is trusted. The halt check compares against the opcode captured one edge earlier, and it is held off until one edge has passed with reset low. The bench drives `opcode_i` only at falling edges and holds it steady across each rising edge. It drives reset only from the idle state or between vectors, so every sampled descriptor belongs to exactly one opcode.

// File: rtl/op_dec_pkg.sv
package op_dec_pkg;

  parameter int OP_W  = 8;
  parameter int FLD_W = 3;
  parameter int CYC_W = 3;
  parameter int LEN_W = 2;

  localparam logic [FLD_W-1:0] REG_IDX_A  = 3'd7;
  localparam logic [FLD_W-1:0] FIELD_HL   = 3'd6;

  typedef enum logic [2:0] {
    CLS_ILLEGAL = 3'd0,
    CLS_LOAD    = 3'd1,
    CLS_STORE   = 3'd2,
    CLS_LOGIC   = 3'd3,
    CLS_CALL    = 3'd4,
    CLS_RET     = 3'd5,
    CLS_INTDIS  = 3'd6,
    CLS_HALT    = 3'd7
  } cls_e;

  typedef enum logic [2:0] {
    OPD_NONE   = 3'd0,
    OPD_REG    = 3'd1,
    OPD_IMM    = 3'd2,
    OPD_MEM_HL = 3'd3,
    OPD_DIR16  = 3'd4,
    OPD_HIGH   = 3'd5
  } opd_e;

  typedef enum logic [1:0] {
    POST_NONE = 2'd0,
    POST_INC  = 2'd1,
    POST_DEC  = 2'd2
  } post_e;

  typedef enum logic [1:0] {
    LOP_NONE = 2'd0,
    LOP_OR   = 2'd1,
    LOP_XOR  = 2'd2,
    LOP_AND  = 2'd3
  } lop_e;

  typedef struct packed {
    cls_e             cls;
    opd_e             dst_kind;
    logic [FLD_W-1:0] dst_reg;
    opd_e             src_kind;
    logic [FLD_W-1:0] src_reg;
    post_e            post;
    lop_e             lop;
    logic [CYC_W-1:0] cycles;
    logic [LEN_W-1:0] len;
    logic             hit;
  } uop_t;

  function automatic uop_t mk_uop(
    input cls_e             c,
    input opd_e             dk,
    input logic [FLD_W-1:0] dr,
    input opd_e             sk,
    input logic [FLD_W-1:0] sr,
    input post_e            p,
    input lop_e             l,
    input int               cy,
    input int               ln
  );
    uop_t u;
    u.cls      = c;
    u.dst_kind = dk;
    u.dst_reg  = dr;
    u.src_kind = sk;
    u.src_reg  = sr;
    u.post     = p;
    u.lop      = l;
    u.cycles   = CYC_W'(cy);
    u.len      = LEN_W'(ln);
    u.hit      = 1'b1;
    return u;
  endfunction

endpackage

// File: rtl/op_dec_fixed.sv
module op_dec_fixed
  import op_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output uop_t            uop_o
);

  always_comb begin
    uop_o = '0;
    case (opcode_i)
      8'hEA: uop_o = mk_uop(CLS_STORE, OPD_DIR16, '0, OPD_REG, REG_IDX_A,
                            POST_NONE, LOP_NONE, 4, 3);
      8'hE0: uop_o = mk_uop(CLS_STORE, OPD_HIGH, '0, OPD_REG, REG_IDX_A,
                            POST_NONE, LOP_NONE, 3, 2);
      8'h22: uop_o = mk_uop(CLS_STORE, OPD_MEM_HL, '0, OPD_REG, REG_IDX_A,
                            POST_INC, LOP_NONE, 2, 1);
      8'h32: uop_o = mk_uop(CLS_STORE, OPD_MEM_HL, '0, OPD_REG, REG_IDX_A,
                            POST_DEC, LOP_NONE, 2, 1);
      8'h2A: uop_o = mk_uop(CLS_LOAD, OPD_REG, REG_IDX_A, OPD_MEM_HL, '0,
                            POST_INC, LOP_NONE, 2, 1);
      8'h3A: uop_o = mk_uop(CLS_LOAD, OPD_REG, REG_IDX_A, OPD_MEM_HL, '0,
                            POST_DEC, LOP_NONE, 2, 1);
      8'hB6: uop_o = mk_uop(CLS_LOGIC, OPD_REG, REG_IDX_A, OPD_MEM_HL, '0,
                            POST_NONE, LOP_OR, 2, 1);
      8'hAE: uop_o = mk_uop(CLS_LOGIC, OPD_REG, REG_IDX_A, OPD_MEM_HL, '0,
                            POST_NONE, LOP_XOR, 2, 1);
      8'hA6: uop_o = mk_uop(CLS_LOGIC, OPD_REG, REG_IDX_A, OPD_MEM_HL, '0,
                            POST_NONE, LOP_AND, 2, 1);
      8'hCD: uop_o = mk_uop(CLS_CALL, OPD_NONE, '0, OPD_NONE, '0,
                            POST_NONE, LOP_NONE, 6, 3);
      8'hC9: uop_o = mk_uop(CLS_RET, OPD_NONE, '0, OPD_NONE, '0,
                            POST_NONE, LOP_NONE, 4, 1);
      8'hF3: uop_o = mk_uop(CLS_INTDIS, OPD_NONE, '0, OPD_NONE, '0,
                            POST_NONE, LOP_NONE, 1, 1);
      8'h76: uop_o = mk_uop(CLS_HALT, OPD_NONE, '0, OPD_NONE, '0,
                            POST_NONE, LOP_NONE, 1, 1);
      default: uop_o = '0;
    endcase
  end

endmodule

// File: rtl/op_dec_pattern.sv
module op_dec_pattern
  import op_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output uop_t            uop_o
);

  logic [1:0]       grp;
  logic [FLD_W-1:0] fld_dst;
  logic [FLD_W-1:0] fld_src;
  logic             dst_is_mem;
  logic             src_is_mem;

  assign grp        = opcode_i[7:6];
  assign fld_dst    = opcode_i[5:3];
  assign fld_src    = opcode_i[2:0];
  assign dst_is_mem = (fld_dst == FIELD_HL);
  assign src_is_mem = (fld_src == FIELD_HL);

  always_comb begin
    uop_o = '0;
    if (grp == 2'b00 && src_is_mem) begin
      uop_o.hit      = 1'b1;
      uop_o.src_kind = OPD_IMM;
      uop_o.cycles   = CYC_W'(2);
      uop_o.len      = LEN_W'(2);
      if (dst_is_mem) begin
        uop_o.cls      = CLS_STORE;
        uop_o.dst_kind = OPD_MEM_HL;
      end else begin
        uop_o.cls      = CLS_LOAD;
        uop_o.dst_kind = OPD_REG;
        uop_o.dst_reg  = fld_dst;
      end
    end else if (grp == 2'b01) begin
      uop_o.hit    = 1'b1;
      uop_o.cycles = CYC_W'(1);
      uop_o.len    = LEN_W'(1);
      if (dst_is_mem) begin
        uop_o.cls      = CLS_STORE;
        uop_o.dst_kind = OPD_MEM_HL;
      end else begin
        uop_o.cls      = CLS_LOAD;
        uop_o.dst_kind = OPD_REG;
        uop_o.dst_reg  = fld_dst;
      end
      if (src_is_mem) begin
        uop_o.src_kind = OPD_MEM_HL;
      end else begin
        uop_o.src_kind = OPD_REG;
        uop_o.src_reg  = fld_src;
      end
    end
  end

endmodule

// File: rtl/op_dec_merge.sv
module op_dec_merge
  import op_dec_pkg::*;
(
  input  uop_t fixed_i,
  input  uop_t pat_i,
  output uop_t uop_o,
  output logic illegal_o
);

  uop_t illegal_uop;

  always_comb begin
    illegal_uop        = '0;
    illegal_uop.cycles = CYC_W'(1);
    illegal_uop.len    = LEN_W'(1);
  end

  always_comb begin
    if (fixed_i.hit) begin
      uop_o = fixed_i;
    end else if (pat_i.hit) begin
      uop_o = pat_i;
    end else begin
      uop_o = illegal_uop;
    end
    illegal_o = !(fixed_i.hit || pat_i.hit);
  end

endmodule

// File: rtl/op_decoder.sv
module op_decoder
  import op_dec_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode_i,
  output logic [2:0]       cls_o,
  output logic [2:0]       dst_kind_o,
  output logic [FLD_W-1:0] dst_reg_o,
  output logic [2:0]       src_kind_o,
  output logic [FLD_W-1:0] src_reg_o,
  output logic [1:0]       post_o,
  output logic [1:0]       logic_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic [LEN_W-1:0] len_o,
  output logic             illegal_o
);

  uop_t fixed_uop;
  uop_t pat_uop;
  uop_t comb_uop;
  logic comb_illegal;
  uop_t out_uop;
  logic out_illegal;

  op_dec_fixed u_fixed (
    .opcode_i (opcode_i),
    .uop_o    (fixed_uop)
  );

  op_dec_pattern u_pattern (
    .opcode_i (opcode_i),
    .uop_o    (pat_uop)
  );

  op_dec_merge u_merge (
    .fixed_i   (fixed_uop),
    .pat_i     (pat_uop),
    .uop_o     (comb_uop),
    .illegal_o (comb_illegal)
  );

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_uop     <= '0;
          out_illegal <= 1'b0;
        end else begin
          out_uop     <= comb_uop;
          out_illegal <= comb_illegal;
        end
      end
    end else begin : g_comb
      assign out_uop     = comb_uop;
      assign out_illegal = comb_illegal;
    end
  endgenerate

  assign cls_o      = out_uop.cls;
  assign dst_kind_o = out_uop.dst_kind;
  assign dst_reg_o  = out_uop.dst_reg;
  assign src_kind_o = out_uop.src_kind;
  assign src_reg_o  = out_uop.src_reg;
  assign post_o     = out_uop.post;
  assign logic_o    = out_uop.lop;
  assign cycles_o   = out_uop.cycles;
  assign len_o      = out_uop.len;
  assign illegal_o  = out_illegal;

endmodule

// File: rtl/op_dec_checker.sv
module op_dec_checker
  import op_dec_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  opcode_i,
  input logic [2:0]       cls_o,
  input logic [2:0]       dst_kind_o,
  input logic [FLD_W-1:0] dst_reg_o,
  input logic [2:0]       src_kind_o,
  input logic [FLD_W-1:0] src_reg_o,
  input logic [1:0]       post_o,
  input logic [1:0]       logic_o,
  input logic [CYC_W-1:0] cycles_o,
  input logic [LEN_W-1:0] len_o,
  input logic             illegal_o
);

  logic [OP_W-1:0] op_q;
  logic            rst_q;
  logic            primed;
  logic [OP_W-1:0] op_ref;

  always_ff @(posedge clk) begin
    op_q  <= opcode_i;
    rst_q <= rst;
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assign op_ref = (REG_OUT != 0) ? op_q : opcode_i;

  // R1: the edge after a reset edge shows a cleared descriptor
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT != 0 && rst_q === 1'b1) |->
      (cls_o == 3'd0 && illegal_o == 1'b0 && len_o == '0 && cycles_o == '0));

  // R2: direct-address destination always carries its long form
  a_r2_dir16_shape: assert property (@(posedge clk) disable iff (rst)
    (dst_kind_o == 3'd4) |-> (cycles_o == CYC_W'(4) && len_o == LEN_W'(3)));

  // R3: a pointer step only accompanies a memory-at-HL operand
  a_r3_post_needs_hl: assert property (@(posedge clk) disable iff (rst)
    (post_o != 2'd0) |-> (dst_kind_o == 3'd3 || src_kind_o == 3'd3));

  // R5: a logic function implies the logic class
  a_r5_logic_class: assert property (@(posedge clk) disable iff (rst)
    (logic_o != 2'd0) |-> (cls_o == 3'd3));

  // R8: register index 6 never appears as a register operand
  a_r8_no_reg6_dst: assert property (@(posedge clk) disable iff (rst)
    (dst_kind_o == 3'd1) |-> (dst_reg_o != 3'd6));
  a_r8_no_reg6_src: assert property (@(posedge clk) disable iff (rst)
    (src_kind_o == 3'd1) |-> (src_reg_o != 3'd6));

  // R9: the halt slot decodes as halt, not as a copy
  a_r9_halt_slot: assert property (@(posedge clk) disable iff (rst || !primed)
    (op_ref == 8'h76) |-> (cls_o == 3'd7 && illegal_o == 1'b0));

  // R10: illegal descriptors have a fixed shape
  a_r10_illegal_shape: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (cls_o == 3'd0 && len_o == LEN_W'(1) &&
                   cycles_o == CYC_W'(1) && post_o == 2'd0));

endmodule

bind op_decoder op_dec_checker #(.REG_OUT(REG_OUT)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .opcode_i   (opcode_i),
  .cls_o      (cls_o),
  .dst_kind_o (dst_kind_o),
  .dst_reg_o  (dst_reg_o),
  .src_kind_o (src_kind_o),
  .src_reg_o  (src_reg_o),
  .post_o     (post_o),
  .logic_o    (logic_o),
  .cycles_o   (cycles_o),
  .len_o      (len_o),
  .illegal_o  (illegal_o)
);

// File: tb/op_decoder_bench.sv
module op_decoder_bench;

  localparam int NVEC = 33;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode_i = 8'h00;
  logic [2:0] cls_o, dst_kind_o, dst_reg_o, src_kind_o, src_reg_o;
  logic [1:0] post_o, logic_o, len_o;
  logic [2:0] cycles_o;
  logic       illegal_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  op_decoder u_op_decoder (
    .clk        (clk),
    .rst        (rst),
    .opcode_i   (opcode_i),
    .cls_o      (cls_o),
    .dst_kind_o (dst_kind_o),
    .dst_reg_o  (dst_reg_o),
    .src_kind_o (src_kind_o),
    .src_reg_o  (src_reg_o),
    .post_o     (post_o),
    .logic_o    (logic_o),
    .cycles_o   (cycles_o),
    .len_o      (len_o),
    .illegal_o  (illegal_o)
  );

  // vector: {req[3:0], opcode[7:0], descriptor[24:0]}
  function automatic logic [36:0] mkv(int r, int op, int c, int dk, int dr,
                                      int sk, int sr, int po, int lo,
                                      int cy, int ln, int il);
    return {4'(r), 8'(op), 3'(c), 3'(dk), 3'(dr), 3'(sk), 3'(sr),
            2'(po), 2'(lo), 3'(cy), 2'(ln), 1'(il)};
  endfunction

  localparam logic [36:0] VEC [NVEC] = '{
    mkv(2, 'hEA, 2, 4, 0, 1, 7, 0, 0, 4, 3, 0),   // R2
    mkv(2, 'hE0, 2, 5, 0, 1, 7, 0, 0, 3, 2, 0),   // R2
    mkv(3, 'h22, 2, 3, 0, 1, 7, 1, 0, 2, 1, 0),   // R3
    mkv(3, 'h32, 2, 3, 0, 1, 7, 2, 0, 2, 1, 0),   // R3
    mkv(4, 'h2A, 1, 1, 7, 3, 0, 1, 0, 2, 1, 0),   // R4
    mkv(4, 'h3A, 1, 1, 7, 3, 0, 2, 0, 2, 1, 0),   // R4
    mkv(5, 'hB6, 3, 1, 7, 3, 0, 0, 1, 2, 1, 0),   // R5
    mkv(5, 'hAE, 3, 1, 7, 3, 0, 0, 2, 2, 1, 0),   // R5
    mkv(5, 'hA6, 3, 1, 7, 3, 0, 0, 3, 2, 1, 0),   // R5
    mkv(6, 'hCD, 4, 0, 0, 0, 0, 0, 0, 6, 3, 0),   // R6
    mkv(6, 'hC9, 5, 0, 0, 0, 0, 0, 0, 4, 1, 0),   // R6
    mkv(6, 'hF3, 6, 0, 0, 0, 0, 0, 0, 1, 1, 0),   // R6
    mkv(7, 'h06, 1, 1, 0, 2, 0, 0, 0, 2, 2, 0),   // R7
    mkv(7, 'h3E, 1, 1, 7, 2, 0, 0, 0, 2, 2, 0),   // R7
    mkv(7, 'h2E, 1, 1, 5, 2, 0, 0, 0, 2, 2, 0),   // R7
    mkv(7, 'h36, 2, 3, 0, 2, 0, 0, 0, 2, 2, 0),   // R7
    mkv(8, 'h78, 1, 1, 7, 1, 0, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h41, 1, 1, 0, 1, 1, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h40, 1, 1, 0, 1, 0, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h6C, 1, 1, 5, 1, 4, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h7E, 1, 1, 7, 3, 0, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h77, 2, 3, 0, 1, 7, 0, 0, 1, 1, 0),   // R8
    mkv(8, 'h70, 2, 3, 0, 1, 0, 0, 0, 1, 1, 0),   // R8
    mkv(9, 'h76, 7, 0, 0, 0, 0, 0, 0, 1, 1, 0),   // R9
    mkv(8, 'h75, 2, 3, 0, 1, 5, 0, 0, 1, 1, 0),   // R8 neighbour of halt
    mkv(10, 'h00, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'hFF, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'hCB, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'h02, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'h80, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'hC3, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'h37, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1),  // R10
    mkv(10, 'hE2, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1)   // R10
  };

  function automatic logic [24:0] got_desc();
    return {cls_o, dst_kind_o, dst_reg_o, src_kind_o, src_reg_o,
            post_o, logic_o, cycles_o, len_o, illegal_o};
  endfunction

  task automatic check(input string req, input logic [24:0] act,
                       input logic [24:0] exp, input logic [7:0] op);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%02h actual=%07h expected=%07h", req, op, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op);
    @(negedge clk);
    opcode_i = op;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int illegal_cnt;
    logic copy_ok;
    // R1: reset clears all outputs
    opcode_i = 8'h3E;
    repeat (3) @(posedge clk);
    #1;
    check("R1", got_desc(), 25'd0, 8'h3E);
    @(negedge clk);
    rst = 1'b0;

    // R1: latency of one edge
    apply(8'h00);
    @(negedge clk);
    opcode_i = 8'hEA;
    #1;
    check("R1", got_desc(), mkv(0,0,0,0,0,0,0,0,0,1,1,1), 8'hEA);
    @(posedge clk);
    #1;
    check("R1", got_desc(), mkv(0,0,2,4,0,1,7,0,0,4,3,0), 8'hEA);

    // R2 .. R10 vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][32:25]);
      check($sformatf("R%0d", int'(VEC[i][36:33])), got_desc(),
            VEC[i][24:0], VEC[i][32:25]);
    end

    // R1: reset mid-stream with a legal opcode held
    apply(8'hCD);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", got_desc(), 25'd0, 8'hCD);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1", got_desc(), mkv(0,0,4,0,0,0,0,0,0,6,3,0), 8'hCD);

    // R10: full sweep illegal count; R8: copy group never illegal
    illegal_cnt = 0;
    copy_ok = 1'b1;
    for (int op = 0; op < 256; op++) begin
      apply(8'(op));
      if (illegal_o) illegal_cnt++;
      if (op >= 'h40 && op < 'h80 && (illegal_o || cls_o == 3'd0)) copy_ok = 1'b0;
    end
    check("R10", 25'(illegal_cnt), 25'd172, 8'hFF);
    check("R8", 25'(copy_ok), 25'd1, 8'h40);

    done = 1'b1;
    finish_run();
  end

endmodule